// File: doc/BRIEF.md
# Programmable Watchdog Reset Timer

This block guards a processor against runaway software. A counter runs on its own slow watchdog clock, which is independent of the processor clock. Once enabled, the counter must be restarted by software before it reaches a programmable terminal count. If software fails to restart it in time, the block drives a reset pulse of fixed width into the processor clock domain. Software reaches one control register through a byte-wide register bus. The register holds an enable bit, a self-clearing restart bit and a 3-bit period code. The period code picks one of eight timeouts. Each code doubles the timeout of the one below it, from `BASE_TICKS` up to `BASE_TICKS << 7` watchdog clock ticks.

The register bus side runs a two-state machine. In `C_IDLE` it accepts register writes. It moves to `C_PULSE` when an expiry event arrives while the enable bit is set, and it returns to `C_IDLE` after `PULSE_W` processor clocks. The watchdog clock side runs a three-state machine:

- `W_OFF` moves to `W_RUN` when the synchronized enable bit is seen. On that move it clears the count and latches the limit.
- `W_RUN` moves back to `W_OFF` when the enable bit drops.
- `W_RUN` stays in `W_RUN` on a restart event. It clears the count and latches a new limit.
- `W_RUN` moves to `W_FIRE` when the count reaches its limit. On that move it flips the expiry toggle.
- `W_FIRE` always returns to `W_OFF`.

Control crosses from the bus side to the watchdog clock side through two-flop synchronizers. Restart travels as a toggle, and so does the expiry event on its way back. The period code travels as a held copy that changes only when an enable or a restart is written.

Top module: `wdt_guard`

## Requirements
- R1: After power-on reset (`rst_ni` low), the control register reads 0x00, `cpu_rst_o` is low, and no reset pulse occurs until the timer is enabled.
- R2: The control register sits at address `ADDR` (default 0x96) with this layout: bit 0 is enable, bit 1 is restart, and bits 6:4 hold the period code. Restart always reads 0, and bits 7, 3 and 2 read 0. A read at any other address returns 0x00, and a write there has no effect.
- R3: When the timer is enabled with period code p and is never restarted, it produces exactly one reset pulse. The pulse starts between (limit+1) and (limit+5) watchdog clock periods after the enabling write, where limit = `BASE_TICKS << p`.
- R4: Writing 1 to the restart bit while the timer is enabled starts a new full period. The pulse then starts between (limit+1) and (limit+5) watchdog periods after the last restart write, and no pulse occurs before that.
- R5: A new period code written without restart, while the timer is running, does not change the running period. It does read back at once. A code written together with restart applies from that restart.
- R6: Each reset pulse is high for exactly `PULSE_W` processor clock cycles.
- R7: The enable bit reads 0 once a reset pulse has ended.
- R8: While `pdown_i` is high, the enable bit is forced to 0, writes that try to set it are ignored, and no reset pulse starts.
- R9: Writing 0 to the enable bit before expiry cancels the timeout: no reset pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Processor clock |
| wclk_i | input | 1 | Free-running watchdog clock, asynchronous to clk_i |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| pdown_i | input | 1 | Power-down indication; forces the timer off |
| sfr_we_i | input | 1 | Register write strobe |
| sfr_addr_i | input | 8 | Register address |
| sfr_wdata_i | input | 8 | Register write data |
| sfr_rdata_o | output | 8 | Register read data, combinational on the address |
| cpu_rst_o | output | 1 | Reset pulse to the processor, synchronous to clk_i |

## Verification
The bench builds the block with `BASE_TICKS` = 4 and `PULSE_W` = 4. It uses a 40 ns watchdog clock against the 4 ns processor clock. With these values the longest code, 512 ticks, expires in about 5,000 processor cycles, so all eight period codes are measured within a short run. The four-cycle pulse keeps each width check short. The 4-to-512 range is still wide enough that a period off by one code falls clearly outside each measured window.

// File: rtl/wdt_guard_pkg.sv
`timescale 1ns/1ps
package wdt_guard_pkg;

    // Watchdog clock side states
    typedef enum logic [1:0] {
        W_OFF  = 2'd0,
        W_RUN  = 2'd1,
        W_FIRE = 2'd2
    } wd_state_t;

    // Processor clock side states
    typedef enum logic {
        C_IDLE  = 1'b0,
        C_PULSE = 1'b1
    } rst_state_t;

    // Control register field positions
    localparam int EN_BIT = 0;
    localparam int RS_BIT = 1;
    localparam int PS_LSB = 4;

endpackage

// File: rtl/wdt_guard_sync.sv
`timescale 1ns/1ps
module wdt_guard_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] s1_q;
    logic [WIDTH-1:0] s2_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;

endmodule

// File: rtl/wdt_guard_core.sv
`timescale 1ns/1ps
module wdt_guard_core
    import wdt_guard_pkg::*;
#(
    parameter int BASE_TICKS = 512,
    parameter int PS_W       = 3
) (
    input  logic            wclk_i,
    input  logic            rst_ni,
    input  logic            en_s_i,
    input  logic            rs_s_i,
    input  logic [PS_W-1:0] ps_i,
    output logic            exp_tgl_o
);

    localparam int MAX_TICKS = BASE_TICKS << ((1 << PS_W) - 1);
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    wd_state_t        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] lim_q, lim_d;
    logic             tgl_q, tgl_d;
    logic             rs_prev_q;
    logic             rs_evt;

    function automatic logic [CNT_W-1:0] lim_for(input logic [PS_W-1:0] p);
        return CNT_W'(BASE_TICKS) << p;
    endfunction

    assign rs_evt = rs_s_i ^ rs_prev_q;

    // State register
    always_ff @(posedge wclk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q      <= W_OFF;
            cnt_q     <= '0;
            lim_q     <= CNT_W'(BASE_TICKS);
            tgl_q     <= 1'b0;
            rs_prev_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            cnt_q     <= cnt_d;
            lim_q     <= lim_d;
            tgl_q     <= tgl_d;
            rs_prev_q <= rs_s_i;
        end
    end

    // Next state and counter
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        lim_d = lim_q;
        tgl_d = tgl_q;
        unique case (st_q)
            W_OFF: begin
                if (en_s_i) begin
                    st_d  = W_RUN;
                    cnt_d = '0;
                    lim_d = lim_for(ps_i);
                end
            end
            W_RUN: begin
                if (!en_s_i) begin
                    st_d  = W_OFF;
                    cnt_d = '0;
                end else if (rs_evt) begin
                    cnt_d = '0;
                    lim_d = lim_for(ps_i);
                end else if (cnt_q == lim_q - CNT_W'(1)) begin
                    st_d  = W_FIRE;
                    cnt_d = '0;
                    tgl_d = !tgl_q;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            W_FIRE: st_d = W_OFF;
            default: st_d = W_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        exp_tgl_o = tgl_q;
    end

    // R3: the count never passes the latched limit while running
    p_cnt_in_range_r3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
        (st_q == W_RUN) |-> (cnt_q < lim_q));

    // R3: an expiry is only ever entered from a running count
    p_fire_from_run_r3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
        (st_q == W_FIRE) |-> ($past(st_q) == W_RUN));

endmodule

// File: rtl/wdt_guard_ctrl.sv
`timescale 1ns/1ps
module wdt_guard_ctrl
    import wdt_guard_pkg::*;
#(
    parameter logic [7:0] ADDR    = 8'h96,
    parameter int         PS_W    = 3,
    parameter int         PULSE_W = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            pdown_i,
    input  logic            sfr_we_i,
    input  logic [7:0]      sfr_addr_i,
    input  logic [7:0]      sfr_wdata_i,
    output logic [7:0]      sfr_rdata_o,
    input  logic            exp_s_i,
    output logic            en_o,
    output logic            rs_tgl_o,
    output logic [PS_W-1:0] ps_hold_o,
    output logic            cpu_rst_o
);

    localparam int PC_W = $clog2(PULSE_W + 1);

    rst_state_t      st_q, st_d;
    logic [PC_W-1:0] pc_q, pc_d;
    logic            en_q, en_d;
    logic [PS_W-1:0] ps_q, ps_hold_q;
    logic            rs_tgl_q;
    logic            exp_prev_q;

    logic            hit, wr, exp_evt, fire, accept;
    logic            w_en, w_rs;
    logic [PS_W-1:0] w_ps;
    logic            unused_wd;

    assign hit       = (sfr_addr_i == ADDR);
    assign wr        = sfr_we_i && hit;
    assign w_en      = sfr_wdata_i[EN_BIT];
    assign w_rs      = sfr_wdata_i[RS_BIT];
    assign w_ps      = sfr_wdata_i[PS_LSB +: PS_W];
    assign unused_wd = ^sfr_wdata_i;
    assign exp_evt   = exp_s_i ^ exp_prev_q;
    assign fire      = (st_q == C_IDLE) && exp_evt && en_q;
    assign accept    = wr && !pdown_i && (st_q == C_IDLE) && !fire;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q       <= C_IDLE;
            pc_q       <= '0;
            en_q       <= 1'b0;
            ps_q       <= '0;
            ps_hold_q  <= '0;
            rs_tgl_q   <= 1'b0;
            exp_prev_q <= 1'b0;
        end else begin
            st_q       <= st_d;
            pc_q       <= pc_d;
            en_q       <= en_d;
            exp_prev_q <= exp_s_i;
            if (wr) begin
                ps_q <= w_ps;
            end
            if (accept && (w_rs || (w_en && !en_q))) begin
                ps_hold_q <= w_ps;
            end
            if (accept && w_rs) begin
                rs_tgl_q <= !rs_tgl_q;
            end
        end
    end

    // Next state, pulse counter and enable
    always_comb begin
        st_d = st_q;
        pc_d = pc_q;
        unique case (st_q)
            C_IDLE: begin
                if (fire) begin
                    st_d = C_PULSE;
                    pc_d = '0;
                end
            end
            C_PULSE: begin
                if (pc_q == PC_W'(PULSE_W - 1)) begin
                    st_d = C_IDLE;
                    pc_d = '0;
                end else begin
                    pc_d = pc_q + PC_W'(1);
                end
            end
            default: st_d = C_IDLE;
        endcase

        if (pdown_i || fire || (st_q == C_PULSE)) begin
            en_d = 1'b0;
        end else if (wr) begin
            en_d = w_en;
        end else begin
            en_d = en_q;
        end
    end

    // Outputs
    always_comb begin
        cpu_rst_o   = (st_q == C_PULSE);
        en_o        = en_q;
        rs_tgl_o    = rs_tgl_q;
        ps_hold_o   = ps_hold_q;
        sfr_rdata_o = '0;
        if (hit) begin
            sfr_rdata_o[EN_BIT]            = en_q;
            sfr_rdata_o[PS_LSB +: PS_W]    = ps_q;
        end
    end

    // Width counter observing the reset output
    logic [15:0] hi_cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hi_cnt_q <= '0;
        end else if (cpu_rst_o) begin
            hi_cnt_q <= hi_cnt_q + 16'd1;
        end else begin
            hi_cnt_q <= '0;
        end
    end

    // R6: the pulse lasts exactly PULSE_W processor clocks
    p_pulse_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cpu_rst_o) |-> (hi_cnt_q == 16'(PULSE_W)));

    // R7: the enable bit is clear once the pulse has ended
    p_en_clear_after_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cpu_rst_o) |-> !en_q);

    // R8: power-down held beforehand means no new pulse
    p_no_pulse_pdown_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(pdown_i, 2) |-> !$rose(cpu_rst_o));

    // R8: enable cannot be seen set one cycle after power-down
    p_pdown_clears_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pdown_i |=> !en_q);

endmodule

// File: rtl/wdt_guard.sv
`timescale 1ns/1ps
module wdt_guard #(
    parameter logic [7:0] ADDR       = 8'h96,
    parameter int         BASE_TICKS = 512,
    parameter int         PS_W       = 3,
    parameter int         PULSE_W    = 16
) (
    input  logic       clk_i,
    input  logic       wclk_i,
    input  logic       rst_ni,
    input  logic       pdown_i,
    input  logic       sfr_we_i,
    input  logic [7:0] sfr_addr_i,
    input  logic [7:0] sfr_wdata_i,
    output logic [7:0] sfr_rdata_o,
    output logic       cpu_rst_o
);

    logic            en_c, rs_tgl_c, exp_tgl_w, exp_s_c;
    logic [PS_W-1:0] ps_hold_c;
    logic [1:0]      ctl_w;

    wdt_guard_ctrl #(
        .ADDR    (ADDR),
        .PS_W    (PS_W),
        .PULSE_W (PULSE_W)
    ) u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pdown_i     (pdown_i),
        .sfr_we_i    (sfr_we_i),
        .sfr_addr_i  (sfr_addr_i),
        .sfr_wdata_i (sfr_wdata_i),
        .sfr_rdata_o (sfr_rdata_o),
        .exp_s_i     (exp_s_c),
        .en_o        (en_c),
        .rs_tgl_o    (rs_tgl_c),
        .ps_hold_o   (ps_hold_c),
        .cpu_rst_o   (cpu_rst_o)
    );

    // Processor clock to watchdog clock: enable level and restart toggle
    wdt_guard_sync #(.WIDTH(2)) u_sync_w (
        .clk_i  (wclk_i),
        .rst_ni (rst_ni),
        .d_i    ({rs_tgl_c, en_c}),
        .q_o    (ctl_w)
    );

    wdt_guard_core #(
        .BASE_TICKS (BASE_TICKS),
        .PS_W       (PS_W)
    ) u_core (
        .wclk_i    (wclk_i),
        .rst_ni    (rst_ni),
        .en_s_i    (ctl_w[0]),
        .rs_s_i    (ctl_w[1]),
        .ps_i      (ps_hold_c),
        .exp_tgl_o (exp_tgl_w)
    );

    // Watchdog clock to processor clock: expiry toggle
    wdt_guard_sync #(.WIDTH(1)) u_sync_c (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (exp_tgl_w),
        .q_o    (exp_s_c)
    );

endmodule

// File: tb/wdt_guard_test.sv
`timescale 1ns/1ps
module wdt_guard_test;

    localparam int         BASE = 4;
    localparam int         PW   = 4;
    localparam logic [7:0] A    = 8'h96;
    localparam real        TW   = 40.0;

    logic       clk = 1'b0, wclk = 1'b0, rst_n = 1'b0, pdown = 1'b0, we = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic [7:0] rdata;
    logic       rsto;

    int      total = 0, bad = 0, npulse = 0, width = 0, last_width = 0;
    logic    prev = 1'b0;
    bit      done = 1'b0;
    realtime rise_t = 0.0, t_wr = 0.0;

    wdt_guard #(.ADDR(A), .BASE_TICKS(BASE), .PS_W(3), .PULSE_W(PW)) uut (
        .clk_i(clk), .wclk_i(wclk), .rst_ni(rst_n), .pdown_i(pdown),
        .sfr_we_i(we), .sfr_addr_i(addr), .sfr_wdata_i(wdata),
        .sfr_rdata_o(rdata), .cpu_rst_o(rsto));

    always #2 clk = ~clk;
    initial begin
        #7;
        forever #20 wclk = ~wclk;
    end

    // Pulse monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rsto && !prev) begin
            npulse <= npulse + 1;
            rise_t <= $realtime;
            width  <= 1;
        end else if (rsto) begin
            width <= width + 1;
        end else if (prev) begin
            last_width <= width;
        end
        prev <= rsto;
    end

    function automatic logic [7:0] ctrl(input bit en, input int ps, input bit rs);
        return (8'(ps) << 4) | (8'(rs) << 1) | 8'(en);
    endfunction

    function automatic int lim(input int ps);
        return BASE << ps;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        t_wr  = $realtime;
        addr  = a;
        wdata = d;
        we    = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic idle(input int n);
        #(n * TW);
    endtask

    task automatic expect_pulse(input realtime t0, input int n0, input int ps,
                                input string req);
        logic [7:0] v;
        int el;
        while (npulse == n0 && ($realtime - t0) < (lim(ps) + 8) * TW) @(negedge clk);
        chk(npulse == n0 + 1, req, "pulse count", npulse - n0, 1);
        el = int'(rise_t - t0);
        chk(el >= int'((lim(ps) + 1) * TW) && el <= int'((lim(ps) + 5) * TW),
            req, "pulse delay ns", el, int'((lim(ps) + 3) * TW));
        repeat (PW + 3) @(negedge clk);
        chk(last_width == PW, "R6", "pulse width", last_width, PW);
        rd(A, v);
        chk(v[0] == 1'b0, "R7", "enable after pulse", int'(v[0]), 0);
        idle(12);
        chk(npulse == n0 + 1, req, "single pulse", npulse - n0, 1);
    endtask

    initial begin
        #700000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n0, cur, nrs, d, p2;
        realtime tref;
        void'($urandom(32'd20240611));

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        rd(A, v);
        chk(v == 8'h00, "R1", "ctrl after reset", v, 0);
        chk(rsto == 1'b0, "R1", "reset output low", rsto, 0);

        // R2 layout and restart read-back
        wr(A, ctrl(0, 5, 1));
        rd(A, v);
        chk(v == 8'h50, "R2", "readback code5 restart", v, 8'h50);
        wr(A, 8'hFE);
        rd(A, v);
        chk(v == 8'h70, "R2", "reserved bits read 0", v, 8'h70);

        // R1/R9 no pulse while disabled
        n0 = npulse;
        idle(700);
        chk(npulse == n0, "R9", "no pulse while disabled", npulse - n0, 0);

        // R2 other address
        wr(8'h95, 8'h01);
        rd(A, v);
        chk(v[0] == 1'b0, "R2", "write elsewhere ignored", v[0], 0);
        rd(8'h95, v);
        chk(v == 8'h00, "R2", "read elsewhere", v, 0);
        idle(20);
        chk(npulse == n0, "R2", "no pulse after foreign write", npulse - n0, 0);

        // R3 every period code
        for (int p = 0; p < 8; p++) begin
            n0 = npulse;
            wr(A, ctrl(1, p, 0));
            expect_pulse(t_wr, n0, p, "R3");
        end

        // R4 restart defers the timeout
        n0 = npulse;
        wr(A, ctrl(1, 3, 0));
        idle(20);
        wr(A, ctrl(1, 3, 1));
        tref = t_wr;
        chk(npulse == n0, "R4", "no pulse before restart", npulse - n0, 0);
        expect_pulse(tref, n0, 3, "R4");

        // R5 code change without restart keeps the running period
        n0 = npulse;
        wr(A, ctrl(1, 2, 0));
        tref = t_wr;
        idle(4);
        wr(A, ctrl(1, 6, 0));
        rd(A, v);
        chk(v == 8'h61, "R5", "new code reads back", v, 8'h61);
        expect_pulse(tref, n0, 2, "R5");

        // R5 code change with restart applies
        n0 = npulse;
        wr(A, ctrl(1, 1, 0));
        idle(3);
        wr(A, ctrl(1, 4, 1));
        expect_pulse(t_wr, n0, 4, "R5");

        // R8 power-down
        n0 = npulse;
        wr(A, ctrl(1, 2, 0));
        idle(5);
        @(negedge clk);
        pdown = 1'b1;
        rd(A, v);
        chk(v[0] == 1'b0, "R8", "enable cleared by power-down", v[0], 0);
        wr(A, ctrl(1, 2, 0));
        rd(A, v);
        chk(v[0] == 1'b0, "R8", "enable write ignored", v[0], 0);
        idle(40);
        chk(npulse == n0, "R8", "no pulse in power-down", npulse - n0, 0);
        @(negedge clk);
        pdown = 1'b0;
        idle(40);
        chk(npulse == n0, "R8", "no pulse after power-down", npulse - n0, 0);
        rd(A, v);
        chk(v == 8'h20, "R8", "ctrl after power-down", v, 8'h20);

        // R9 disable cancels
        wr(A, ctrl(1, 3, 0));
        idle(10);
        wr(A, ctrl(0, 3, 0));
        idle(60);
        chk(npulse == n0, "R9", "disable cancels timeout", npulse - n0, 0);

        // Random restarts with random codes (R4, R5)
        for (int it = 0; it < 8; it++) begin
            n0  = npulse;
            cur = 2 + int'($urandom_range(0, 3));
            nrs = int'($urandom_range(0, 2));
            wr(A, ctrl(1, cur, 0));
            tref = t_wr;
            for (int k = 0; k < nrs; k++) begin
                d  = int'($urandom_range(1, lim(cur) - 5));
                p2 = 2 + int'($urandom_range(0, 3));
                idle(d);
                wr(A, ctrl(1, p2, 1));
                tref = t_wr;
                cur  = p2;
            end
            chk(npulse == n0, "R4", "no early pulse", npulse - n0, 0);
            expect_pulse(tref, n0, cur, "R4");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule